// File: doc/BRIEF.md
# Conditional-Invert Line Word Encoder

The encoder turns parallel traffic into a DC-balanced serial bit stream. On each word boundary it samples a 16-bit input together with a data strobe, a control strobe and a flag, and builds a 20-bit line word. The line word is a 16-bit word field followed by a 4-bit coding field. The coding field always carries a master transition between its two middle bits, so a receiver can lock onto every word. The encoder sends the word either as built or bit-for-bit complemented. It chooses by comparing the word's own disparity with a running disparity, which keeps the line balanced. When neither strobe is set it inserts an idle word. An optional enhanced mode scrambles the flag bit and the first word-field bit with a short additive sequence.

Upstream logic presents a word and holds it while `word_take` is high. The word is captured at the clock edge that ends that cycle. The next 20 cycles shift it out on `ser_out`, first bit first, and `frame_start` marks the cycle that carries the first bit. One serial bit leaves per clock, so the parallel side must keep pace with one word every 20 cycles.

Top module: `cimt_encoder`

## Requirements
- R1: A line word is 20 serial bits: word-field bits w0..w15, then coding bits c0..c3, with w0 sent first. `frame_start` is high exactly in the cycle w0 is on `ser_out`. `word_take` is high in the cycle c3 is on `ser_out`, and the inputs are sampled at the clock edge that ends that cycle.
- R2: In every word c1 and c2 differ, giving the master transition. c1,c2 = 0,1 marks a word sent as built, and 1,0 marks a complemented word.
- R3: In a word sent as built, c0 is 1 for a data word and 0 for a control or idle word, and c3 is the flag bit.
- R4: In a data word, word-field bit wi equals input bit i for all 16 bits.
- R5: The flag bit of a data word equals `flag_in` when `flag_en` is high. Otherwise it equals an internal toggle that is 0 after reset and inverts after every data word, whatever the state of `flag_en`. Outside enhanced mode, control and idle words carry flag bit 1.
- R6: A control word places input bits 6..0 in w6..w0 and input bits 13..7 in w15..w9, with w7,w8 = 0,1 when sent as built. Input bits 15..14 are ignored. When both strobes are high, the control strobe wins.
- R7: With neither strobe high, an idle word is sent: word field all zeros and coding 0,0,1,1 when sent as built, or all ones and 1,1,0,0 when complemented. Outside enhanced mode, the built form holds a single rising edge, located at the master transition.
- R8: The word disparity d is the number of ones minus the number of zeros in the built 20-bit word. The word is complemented exactly when d and the running disparity are both nonzero and have the same sign. The running disparity starts at 0 and then adds the disparity of the word actually sent.
- R9: In enhanced mode, the flag bit is XORed with bit 6 of a 7-bit scrambler state and w0 is XORed with bit 0, both before the inversion decision. The state resets to all ones and steps once per captured word in every mode, to {s[5:0], s[6]^s[5]} (polynomial x^7+x^6+1).
- R10: While reset is applied and for two clocks after its release, `ser_out`, `frame_start` and `word_take` are 0. After reset, the running disparity, toggle and scrambler return to their initial values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dat_req | input | 1 | Send the input as a data word |
| ctl_req | input | 1 | Send the input as a control word |
| din | input | 16 | Parallel word |
| flag_en | input | 1 | Flag bit taken from `flag_in` instead of the toggle |
| flag_in | input | 1 | User flag for data words |
| enh_mode | input | 1 | Enhanced mode: scramble flag bit and w0 |
| word_take | output | 1 | Inputs are sampled at the end of this cycle |
| frame_start | output | 1 | `ser_out` carries w0 of a word |
| ser_out | output | 1 | Serial line bit |

## Verification
The assertions assume the inputs are stable and defined whenever `word_take` is high. The field checks on idle and data words also assume that `enh_mode` is low when those words are checked, because scrambling alters w0. The bench changes its inputs only on falling edges while `word_take` is high, so every captured word was present for the full sampling cycle. It runs enhanced-mode traffic as separate stretches. Mid-run resets are applied on a falling edge, away from any capture edge.

// File: rtl/cimt_pkg.sv
`timescale 1ns/1ps
package cimt_pkg;
  localparam int unsigned FIELD_W = 16;
  localparam int unsigned CODE_W  = 4;
  localparam int unsigned SCR_W   = 7;

  typedef enum logic [1:0] {
    KIND_IDLE = 2'd0,
    KIND_DATA = 2'd1,
    KIND_CTRL = 2'd2
  } word_kind_e;
endpackage

// File: rtl/cimt_rst_sync.sv
`timescale 1ns/1ps
module cimt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cimt_scrambler.sv
`timescale 1ns/1ps
module cimt_scrambler #(
  parameter int unsigned SCR_W = cimt_pkg::SCR_W,
  parameter int unsigned TAP_A = 6,
  parameter int unsigned TAP_B = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [SCR_W-1:0] state
);
  logic [SCR_W-1:0] state_q;
  logic [SCR_W-1:0] state_d;

  always_comb begin
    if (step) state_d = {state_q[SCR_W-2:0], state_q[TAP_A] ^ state_q[TAP_B]};
    else      state_d = state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '1;
    else        state_q <= state_d;
  end

  assign state = state_q;

  AST_SCR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R9
endmodule

// File: rtl/cimt_word_builder.sv
`timescale 1ns/1ps
module cimt_word_builder
  import cimt_pkg::*;
#(
  parameter int unsigned FW  = FIELD_W,
  parameter int unsigned SW  = SCR_W,
  localparam int unsigned LW = FW + CODE_W,
  localparam int unsigned LO = (FW - 2) / 2,
  localparam int unsigned HI = FW - 2 - LO
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          dat_req,
  input  logic          ctl_req,
  input  logic [FW-1:0] din,
  input  logic          flag_en,
  input  logic          flag_in,
  input  logic          enh_mode,
  input  logic [SW-1:0] scr,
  output logic [LW-1:0] true_word,
  output word_kind_e    kind
);
  logic          tog_q;
  logic          tog_d;
  logic [FW-1:0] field;
  logic [FW-1:0] field_s;
  logic          raw_flag;
  logic          fbit;
  logic          is_data;

  always_comb begin
    if (ctl_req)      kind = KIND_CTRL;
    else if (dat_req) kind = KIND_DATA;
    else              kind = KIND_IDLE;
    is_data = (kind == KIND_DATA);
  end

  always_comb begin
    case (kind)
      KIND_DATA: field = din;
      KIND_CTRL: field = {din[LO+HI-1:LO], 1'b1, 1'b0, din[LO-1:0]};
      default:   field = '0;
    endcase
    field_s    = field;
    field_s[0] = field[0] ^ (enh_mode & scr[0]);
    raw_flag   = is_data ? (flag_en ? flag_in : tog_q) : 1'b1;
    fbit       = raw_flag ^ (enh_mode & scr[SW-1]);
    true_word  = {fbit, 1'b1, 1'b0, is_data, field_s};
  end

  always_comb begin
    tog_d = tog_q;
    if (take && is_data) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  AST_USER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dat_req && !ctl_req && flag_en && !enh_mode) |-> (true_word[LW-1] == flag_in)); // R5
  AST_DATA_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dat_req && !ctl_req) |-> true_word[FW]); // R3
endmodule

// File: rtl/cimt_disparity.sv
`timescale 1ns/1ps
module cimt_disparity #(
  parameter int unsigned LW  = 20,
  localparam int unsigned PC_W = $clog2(LW + 1),
  localparam int unsigned RD_W = PC_W + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [LW-1:0] true_word,
  output logic [LW-1:0] line_word
);
  localparam logic signed [RD_W-1:0] LW_S = RD_W'(LW);

  logic [PC_W-1:0]        pop;
  logic signed [RD_W-1:0] pop_s;
  logic signed [RD_W-1:0] wd;
  logic signed [RD_W-1:0] rd_q;
  logic signed [RD_W-1:0] rd_d;
  logic                   inv;

  always_comb begin
    pop = '0;
    for (int i = 0; i < LW; i++) pop = pop + PC_W'(true_word[i]);
    pop_s = $signed({{(RD_W-PC_W){1'b0}}, pop});
    wd    = (pop_s <<< 1) - LW_S;
    inv   = ((wd > 0) && (rd_q > 0)) || ((wd < 0) && (rd_q < 0));
    line_word = inv ? ~true_word : true_word;
  end

  always_comb begin
    rd_d = rd_q;
    if (take) rd_d = inv ? (rd_q - wd) : (rd_q + wd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  AST_RD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q <= LW_S) && (rd_q >= -LW_S)); // R8
  AST_RD_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (take && inv && (rd_q > 0)) |=> (rd_q < $past(rd_q))); // R8
endmodule

// File: rtl/cimt_serializer.sv
`timescale 1ns/1ps
module cimt_serializer #(
  parameter int unsigned LW  = 20,
  localparam int unsigned CW = $clog2(LW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] line_word,
  output logic          take,
  output logic          frame_start,
  output logic          ser_out
);
  localparam logic [CW-1:0] LAST    = CW'(LW - 1);
  localparam logic [CW-1:0] MID_IDX = CW'(LW - 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] sreg_q, sreg_d;
  logic          run_q, run_d;

  always_comb begin
    take   = run_q && (cnt_q == LAST);
    run_d  = 1'b1;
    cnt_d  = cnt_q;
    sreg_d = sreg_q;
    if (run_q) begin
      cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      sreg_d = take ? line_word : (sreg_q >> 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= LAST;
      sreg_q <= '0;
      run_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sreg_q <= sreg_d;
      run_q  <= run_d;
    end
  end

  assign ser_out     = sreg_q[0];
  assign frame_start = (cnt_q == '0);

  AST_MASTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MID_IDX) |-> (ser_out != $past(ser_out))); // R2
  AST_TAKE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> frame_start); // R1
endmodule

// File: rtl/cimt_encoder.sv
`timescale 1ns/1ps
module cimt_encoder
  import cimt_pkg::*;
#(
  parameter int unsigned FW  = FIELD_W,
  localparam int unsigned LW = FW + CODE_W,
  localparam int unsigned LO = (FW - 2) / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dat_req,
  input  logic          ctl_req,
  input  logic [FW-1:0] din,
  input  logic          flag_en,
  input  logic          flag_in,
  input  logic          enh_mode,
  output logic          word_take,
  output logic          frame_start,
  output logic          ser_out
);
  logic             rst_n_int;
  logic [SCR_W-1:0] scr;
  logic [LW-1:0]    true_word;
  logic [LW-1:0]    line_word;
  word_kind_e       kind;

  cimt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  cimt_scrambler #(.SCR_W(SCR_W)) u_scr (
    .clk(clk), .rst_n(rst_n_int), .step(word_take), .state(scr)
  );

  cimt_word_builder #(.FW(FW), .SW(SCR_W)) u_build (
    .clk(clk), .rst_n(rst_n_int), .take(word_take),
    .dat_req(dat_req), .ctl_req(ctl_req), .din(din),
    .flag_en(flag_en), .flag_in(flag_in), .enh_mode(enh_mode),
    .scr(scr), .true_word(true_word), .kind(kind)
  );

  cimt_disparity #(.LW(LW)) u_disp (
    .clk(clk), .rst_n(rst_n_int), .take(word_take),
    .true_word(true_word), .line_word(line_word)
  );

  cimt_serializer #(.LW(LW)) u_ser (
    .clk(clk), .rst_n(rst_n_int), .line_word(line_word),
    .take(word_take), .frame_start(frame_start), .ser_out(ser_out)
  );

  AST_CTRL_SPLIT: assert property (@(posedge clk) disable iff (!rst_n_int)
    (word_take && ctl_req) |-> (line_word[LO] != line_word[LO+1])); // R6
  AST_IDLE_FIELD: assert property (@(posedge clk) disable iff (!rst_n_int)
    (word_take && (kind == KIND_IDLE) && !enh_mode) |->
      ((line_word[FW-1:0] == '0) || (line_word[FW-1:0] == '1))); // R7
  AST_MID_PAIR: assert property (@(posedge clk) disable iff (!rst_n_int)
    word_take |-> (line_word[FW+1] != line_word[FW+2])); // R2
endmodule

// File: tb/cimt_encoder_tb.sv
`timescale 1ns/1ps
module cimt_encoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dat_req, ctl_req, flag_en, flag_in, enh_mode;
  logic [15:0] din;
  logic        word_take, frame_start, ser_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  int         m_rd;
  logic [6:0] m_scr;
  logic       m_tog;
  logic [31:0] lcg = 32'h1234_5678;

  always #10 clk = ~clk;

  cimt_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .dat_req(dat_req), .ctl_req(ctl_req),
    .din(din), .flag_en(flag_en), .flag_in(flag_in), .enh_mode(enh_mode),
    .word_take(word_take), .frame_start(frame_start), .ser_out(ser_out)
  );

  // {dat, ctl, din[15:0], flag_en, flag_in, enh, expected line word[19:0]}
  localparam logic [40:0] VECS [0:5] = '{
    {1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 20'hC0000}, // R7 idle as built
    {1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 20'h3FFFF}, // R8 idle complemented
    {1'b1, 1'b0, 16'hA5A5, 1'b0, 1'b0, 1'b0, 20'h5A5A5}, // R4 toggle flag 0
    {1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 20'hDFFFF}, // R5 toggle flag 1
    {1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b0, 20'hA0000}, // R5 user flag, R8 invert
    {1'b0, 1'b1, 16'hC07F, 1'b0, 1'b0, 1'b0, 20'hC017F}  // R6 split, R3 class 0
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_rd = 0; m_scr = 7'h7F; m_tog = 1'b0;
  endtask

  task automatic model_word(input logic dat, input logic ctl, input logic [15:0] d,
                            input logic fen, input logic fin, input logic enh,
                            output logic [19:0] w);
    logic [15:0] f;
    logic        isd, raw, fb;
    logic [19:0] t;
    int          dd;
    isd = dat && !ctl;
    if (ctl)      f = {d[13:7], 1'b1, 1'b0, d[6:0]};
    else if (dat) f = d;
    else          f = '0;
    raw  = isd ? (fen ? fin : m_tog) : 1'b1;
    fb   = raw ^ (enh & m_scr[6]);
    f[0] = f[0] ^ (enh & m_scr[0]);
    t    = {fb, 1'b1, 1'b0, isd, f};
    dd   = 2 * $countones(t) - 20;
    if (((dd > 0) && (m_rd > 0)) || ((dd < 0) && (m_rd < 0))) begin
      w = ~t; m_rd = m_rd - dd;
    end else begin
      w = t;  m_rd = m_rd + dd;
    end
    if (isd) m_tog = ~m_tog;
    m_scr = {m_scr[5:0], m_scr[6] ^ m_scr[5]};
  endtask

  task automatic send(input logic dat, input logic ctl, input logic [15:0] d,
                      input logic fen, input logic fin, input logic enh,
                      input logic [19:0] exp, input string req, output logic [19:0] cap);
    logic fs0, tk;
    while (!word_take) @(negedge clk);
    dat_req = dat; ctl_req = ctl; din = d; flag_en = fen; flag_in = fin; enh_mode = enh;
    @(posedge clk);
    fs0 = 1'b0; tk = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cap[i] = ser_out;
      if (i == 0)  fs0 = frame_start;
      if (i == 19) tk  = word_take;
    end
    check(cap == exp, req, {12'h0, cap}, {12'h0, exp});
    check(fs0 && tk, "R1 frame markers", {30'h0, fs0, tk}, 32'h3);
  endtask

  task automatic send_model(input logic dat, input logic ctl, input logic [15:0] d,
                            input logic fen, input logic fin, input logic enh, input string req);
    logic [19:0] e, c;
    model_word(dat, ctl, d, fen, fin, enh, e);
    send(dat, ctl, d, fen, fin, enh, e, req, c);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!ser_out && !frame_start && !word_take, "R10 outputs in reset",
          {29'h0, ser_out, frame_start, word_take}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ser_out && !frame_start && !word_take, "R10 outputs after release",
          {29'h0, ser_out, frame_start, word_take}, 32'h0);
    model_reset();
  endtask

  function automatic logic [31:0] next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] cap;
    logic [40:0] v;
    int          edges;
    dat_req = 0; ctl_req = 0; din = '0; flag_en = 0; flag_in = 0; enh_mode = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    apply_reset();

    for (int k = 0; k < 6; k++) begin
      v = VECS[k];
      model_word(v[40], v[39], v[38:23], v[22], v[21], v[20], cap);
      send(v[40], v[39], v[38:23], v[22], v[21], v[20], v[19:0], "R2 R3 R4 R5 R6 R7 R8 table", cap);
      if (k == 0) begin
        edges = 0;
        for (int i = 1; i < 20; i++) if (cap[i] != cap[i-1]) edges++;
        check(edges == 1 && cap[18] && !cap[17], "R7 single rising edge", edges, 1);
      end
    end

    // R6: both strobes, control wins; bits 15..14 ignored
    send_model(1'b1, 1'b1, 16'h3ABC, 1'b0, 1'b0, 1'b0, "R6 control priority");
    send_model(1'b0, 1'b1, 16'hFABC, 1'b0, 1'b0, 1'b0, "R6 upper bits ignored");

    for (int k = 0; k < 200; k++) begin
      logic [31:0] r;
      r = next_rand();
      send_model(r[0], r[1] & r[2], r[31:16], r[3], r[4], 1'b0, "R3 R4 R5 R8 mixed");
    end

    // mid-run reset, then enhanced idle from fresh state
    apply_reset();
    send(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 20'h40001, "R9 first enhanced idle", cap);
    model_word(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, cap);

    for (int k = 0; k < 200; k++) begin
      logic [31:0] r;
      r = next_rand();
      send_model(r[0], r[1] & r[2], r[31:16], r[3], r[4], 1'b1, "R9 enhanced mixed");
    end

    apply_reset();
    send(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 20'hC0000, "R10 state cleared", cap);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule